// File: doc/BRIEF.md
# Bandwidth-Weighted Output Port Selector

This block picks the output direction for a new packet entering a router of a two-dimensional mesh. It compares the tile's own coordinates with the packet's destination. For each of the four mesh directions it takes the free bandwidth, the full link bandwidth and the bandwidth the packet asks for. It also reads one flag per direction that says whether that link is running at double capacity, because its partner half has been turned around to carry traffic the same way.

Each direction gets a weight. A direction that moves the packet closer scores its free bandwidth times the remaining hop count on its axis, plus the full link bandwidth scaled by the capacity factor. A direction that does not move the packet closer scores only its scaled free bandwidth. A direction whose free bandwidth cannot meet the request scores zero. The block grants the direction with the highest weight, one clock after the head flit is presented. It holds that grant for every later flit of the packet and releases it on the tail flit.

Top module: `bw_port_sel`

## Requirements
- R1: A direction that moves toward the destination weighs avail × |hop| + r × total. The hop count is the X distance for E (index 0, destination X greater) and W (index 1, destination X smaller), and the Y distance for N (index 2, destination Y greater) and S (index 3, destination Y smaller). No term is truncated, even at the widest coordinate and bandwidth values.
- R2: A direction that does not move toward the destination, including any direction on an axis where the offset is zero, weighs r × avail.
- R3: A direction whose available bandwidth is below its requested bandwidth weighs zero and is never granted.
- R4: r is 2 when the direction's bit in `dbl_mode` is set and 1 otherwise.
- R5: The highest weight wins. On equal weights the lowest code wins, in the order E=0, W=1, N=2, S=3.
- R6: If all four weights are zero, `no_route` rises, `out_valid` stays low and nothing is locked.
- R7: When the destination equals the current tile, the local port (code 4) is granted whatever the bandwidth inputs are.
- R8: Once granted, `out_port` and `out_valid` hold through any later head or input change until a tail flit.
- R9: A tail flit while a grant is held clears `out_valid` on the next edge.
- R10: A head flit that is accepted is reflected on the outputs after exactly one clock edge.
- R11: After reset `out_valid` and `no_route` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Head flit of a new packet is present |
| tail_valid | input | 1 | Last flit of the current packet is present |
| cur_x | input | COORD_W | This tile's X coordinate |
| cur_y | input | COORD_W | This tile's Y coordinate |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| avail_bw | input | 4*BW_W | Free bandwidth per direction, E in the low slice |
| total_bw | input | 4*BW_W | Full link bandwidth per direction |
| req_bw | input | 4*BW_W | Requested bandwidth per direction |
| dbl_mode | input | 4 | Link is at double capacity, per direction |
| out_port | output | 3 | Granted port: 0 E, 1 W, 2 N, 3 S, 4 local |
| out_valid | output | 1 | A grant is held |
| no_route | output | 1 | Last head found no usable direction |

## Verification
The hardest case to reach is a truncated weight. It only shows when a large free bandwidth meets the longest hop along a doubled link, so that the sum fills the top bit of the weight. The stimulus puts the destination at the far edge of the mesh with maximum bandwidth. A competing away-direction weight sits just above the wrapped value, so any lost carry flips the grant. The lock is tested by presenting a second head whose inputs favour another port while the first grant is still held.

// File: rtl/bw_port_sel.sv
module bw_port_sel #(
  parameter int COORD_W = 4,
  parameter int BW_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head_valid,
  input  logic                 tail_valid,
  input  logic [COORD_W-1:0]   cur_x,
  input  logic [COORD_W-1:0]   cur_y,
  input  logic [COORD_W-1:0]   dst_x,
  input  logic [COORD_W-1:0]   dst_y,
  input  logic [4*BW_W-1:0]    avail_bw,
  input  logic [4*BW_W-1:0]    total_bw,
  input  logic [4*BW_W-1:0]    req_bw,
  input  logic [3:0]           dbl_mode,
  output logic [2:0]           out_port,
  output logic                 out_valid,
  output logic                 no_route
);
  localparam int NDIR = 4;
  localparam int WT_W = BW_W + COORD_W + 1;
  localparam logic [2:0] LOCAL_PORT = 3'd4;

  logic [COORD_W-1:0] dx_abs, dy_abs;
  logic [NDIR-1:0]    toward;
  logic [NDIR-1:0][WT_W-1:0] weight;
  logic [1:0]         best_dir;
  logic [WT_W-1:0]    best_wt;
  logic               is_local;

  assign toward[0] = dst_x > cur_x;
  assign toward[1] = dst_x < cur_x;
  assign toward[2] = dst_y > cur_y;
  assign toward[3] = dst_y < cur_y;
  assign dx_abs    = toward[0] ? dst_x - cur_x : cur_x - dst_x;
  assign dy_abs    = toward[2] ? dst_y - cur_y : cur_y - dst_y;
  assign is_local  = (dst_x == cur_x) && (dst_y == cur_y);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [BW_W-1:0] av, rq;
    logic [WT_W-1:0] av_w, tot_w, hop_w, r_av, r_tot;
    assign av    = avail_bw[d*BW_W +: BW_W];
    assign rq    = req_bw[d*BW_W +: BW_W];
    assign av_w  = WT_W'(av);
    assign tot_w = WT_W'(total_bw[d*BW_W +: BW_W]);
    assign hop_w = WT_W'((d < 2) ? dx_abs : dy_abs);
    assign r_av  = dbl_mode[d] ? (av_w << 1)  : av_w;
    assign r_tot = dbl_mode[d] ? (tot_w << 1) : tot_w;
    assign weight[d] = (av < rq)    ? '0 :
                       toward[d]    ? (av_w * hop_w) + r_tot :
                                      r_av;
  end

  always_comb begin
    best_dir = 2'd0;
    best_wt  = weight[0];
    for (int i = 1; i < NDIR; i++) begin
      if (weight[i] > best_wt) begin
        best_dir = 2'(i);
        best_wt  = weight[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= 3'd0;
      no_route  <= 1'b0;
    end else if (out_valid) begin
      if (tail_valid) out_valid <= 1'b0;
    end else if (head_valid) begin
      if (is_local) begin
        out_valid <= 1'b1;
        out_port  <= LOCAL_PORT;
        no_route  <= 1'b0;
      end else if (best_wt != '0) begin
        out_valid <= 1'b1;
        out_port  <= {1'b0, best_dir};
        no_route  <= 1'b0;
      end else begin
        no_route  <= 1'b1;
      end
    end
  end

  assert_hold_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !tail_valid |=> out_valid && $stable(out_port));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tail_valid |=> !out_valid);
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && no_route));
  assert_grant_after_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(head_valid));
  assert_legal_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_port <= LOCAL_PORT);
  assert_local_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && head_valid && dst_x == cur_x && dst_y == cur_y
      |=> out_valid && out_port == LOCAL_PORT);
endmodule

// File: tb/bw_port_sel_bench.sv
module bw_port_sel_bench;
  localparam int CW = 4;
  localparam int BW = 8;

  logic clk = 1'b0, rst_n = 1'b0, head_valid = 1'b0, tail_valid = 1'b0;
  logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic [4*BW-1:0] avail_bw = '0, total_bw = '0, req_bw = '0;
  logic [3:0] dbl_mode = '0;
  logic [2:0] out_port;
  logic out_valid, no_route;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bw_port_sel #(.COORD_W(CW), .BW_W(BW)) u_bw_port_sel (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .tail_valid(tail_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .avail_bw(avail_bw), .total_bw(total_bw), .req_bw(req_bw),
    .dbl_mode(dbl_mode), .out_port(out_port), .out_valid(out_valid),
    .no_route(no_route));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setup(input int cx, input int cy, input int dx, input int dy,
                       input int av, input int tot, input int rq, input logic [3:0] dbl);
    cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
    avail_bw = {4{BW'(av)}}; total_bw = {4{BW'(tot)}}; req_bw = {4{BW'(rq)}};
    dbl_mode = dbl;
  endtask

  task automatic head_and_check(input string tag, input int exp_port);
    @(negedge clk) head_valid = 1'b1;
    @(negedge clk) head_valid = 1'b0;
    chk({tag, " valid R10"}, int'(out_valid), 1);
    chk({tag, " port"}, int'(out_port), exp_port);
  endtask

  task automatic release_grant();
    @(negedge clk) tail_valid = 1'b1;
    @(negedge clk) tail_valid = 1'b0;
    chk("R9 release", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    chk("R11 valid", int'(out_valid), 0);
    chk("R11 no_route", int'(no_route), 0);
  endtask

  task automatic t_toward_east();
    setup(2, 2, 5, 2, 10, 20, 0, 4'b0000);   // E 50, others 10
    head_and_check("R1 east", 0);
    release_grant();
  endtask

  task automatic t_starved_tie();
    setup(2, 2, 5, 2, 10, 20, 0, 4'b0000);
    avail_bw[0 +: BW] = 8'd4; req_bw[0 +: BW] = 8'd5; // E zero, W/N/S tie at 10
    head_and_check("R3 R5 tie", 1);
    release_grant();
  endtask

  task automatic t_doubled_away();
    setup(2, 2, 5, 2, 10, 20, 0, 4'b0100);
    avail_bw[0 +: BW] = 8'd4; req_bw[0 +: BW] = 8'd5; // N doubled to 20
    head_and_check("R4 doubled", 2);
    release_grant();
  endtask

  task automatic t_away_beats();
    setup(1, 1, 1, 3, 10, 20, 0, 4'b1000);   // N 40
    avail_bw[3*BW +: BW] = 8'd25;            // S away doubled 50
    head_and_check("R2 away", 3);
    release_grant();
  endtask

  task automatic t_equal_toward();
    setup(0, 0, 1, 1, 10, 20, 0, 4'b0000);   // E 30, N 30
    head_and_check("R5 order", 0);
    release_grant();
  endtask

  task automatic t_wide();
    setup(0, 3, 15, 3, 255, 255, 0, 4'b0000);
    dbl_mode = 4'b0001;                     // E = 3825+510 = 4335
    avail_bw[2*BW +: BW] = 8'd255; dbl_mode[2] = 1'b1; // N away = 510
    head_and_check("R1 wide", 0);
    release_grant();
  endtask

  task automatic t_no_route();
    setup(2, 2, 5, 5, 3, 20, 9, 4'b1111);
    @(negedge clk) head_valid = 1'b1;
    @(negedge clk) head_valid = 1'b0;
    chk("R6 no_route", int'(no_route), 1);
    chk("R6 valid", int'(out_valid), 0);
  endtask

  task automatic t_local();
    setup(3, 3, 3, 3, 3, 20, 9, 4'b0000);
    head_and_check("R7 local", 4);
    chk("R7 no_route cleared", int'(no_route), 0);
    release_grant();
  endtask

  task automatic t_lock();
    setup(2, 2, 5, 2, 10, 20, 0, 4'b0000);
    head_and_check("R8 first", 0);
    setup(5, 2, 2, 2, 10, 20, 0, 4'b0000);   // would favour W
    @(negedge clk) head_valid = 1'b1;
    @(negedge clk) head_valid = 1'b0;
    chk("R8 held valid", int'(out_valid), 1);
    chk("R8 held port", int'(out_port), 0);
    release_grant();
    head_and_check("R8 new packet", 1);
    release_grant();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_toward_east();
    t_starved_tie();
    t_doubled_away();
    t_away_beats();
    t_equal_toward();
    t_wide();
    t_no_route();
    t_local();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule